// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the per-channel completion events of a DMA engine and turns them into a small number of interrupt request lines. Each channel reports completion with a one-cycle pulse. The pulse latches into a shared pending vector unless that channel is in quiet mode. Each interrupt output has its own channel mask and its own software force vector. An output's line is high while any channel is both unmasked and either pending or forced.

Software reaches the state through a simple register port. Writes take effect on the next clock edge. Reads are combinational from the current address. The low two address bits select the register kind. The upper bits select the output that a mask, force or masked-status access refers to.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every pending, mask and force bit is 0, all reads return 0 and every `irq` line is low.
- R2: A `chan_done[n]` pulse while `chan_quiet[n]` is 0 sets pending bit n on the next edge. Other pending bits keep their values.
- R3: A `chan_done[n]` pulse while `chan_quiet[n]` is 1 leaves pending bit n unchanged.
- R4: A write to address kind 2'b00 (pending) clears each pending bit whose write-data bit is 1. Bits written 0 are unchanged. A read of kind 2'b00 returns the pending vector for any output index.
- R5: A write to address kind 2'b11 (masked status) with any output index clears pending bits exactly as R4 does.
- R6: When a completion pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: A write to address kind 2'b01 with output index k loads the mask of output k. A read at that address returns the mask.
- R8: A write to address kind 2'b10 with output index k loads the force vector of output k. Completion pulses and pending clears never change any force vector. A read at that address returns it.
- R9: A read of address kind 2'b11 with output index k returns (pending OR force_k) AND mask_k.
- R10: `irq[k]` is high exactly when the masked status of output k is nonzero.
- R11: Mask and force writes for one output index leave the other output's mask and force unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_done | input | NUM_CH | One-cycle completion pulse per channel |
| chan_quiet | input | NUM_CH | Per-channel quiet mode, suppresses pending set |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | {output index, kind[1:0]} |
| reg_wdata | input | NUM_CH | Write data, one bit per channel |
| reg_rdata | output | NUM_CH | Read data for `reg_addr` |
| irq | output | NUM_OUT | Interrupt request lines |

## Verification
The bench targets a completion pulse that lands in the same cycle as a clearing write to the same bit. A design that gives the clear priority would lose that interrupt. It checks that a quiet channel's pulse never latches, and that the masked-status address clears pending bits from either output index. A design that decodes only one of the two clear addresses would leave those bits pending. It also checks that force bits survive pulses and clears, and that writes aimed at one output never change the other output's mask or force.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    KIND_PENDING = 2'b00,
    KIND_MASK    = 2'b01,
    KIND_FORCE   = 2'b10,
    KIND_STATUS  = 2'b11
  } reg_kind_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] done,
  input  logic [NUM_CH-1:0] quiet,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] pend_q
);
  logic [NUM_CH-1:0] set_vec;
  logic [NUM_CH-1:0] pend_d;
  logic              pend_ld;

  // set takes priority over a clear of the same bit
  always_comb begin
    set_vec = done & ~quiet;
    pend_d  = (pend_q & ~clr_vec) | set_vec;
    pend_ld = (|set_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ld) pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              force_we,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] force_q,
  output logic [NUM_CH-1:0] status,
  output logic              irq
);
  logic [NUM_CH-1:0] mask_d;
  logic [NUM_CH-1:0] force_d;

  always_comb begin
    mask_d  = wdata;
    force_d = wdata;
    status  = (pend | force_q) & mask_q;
    irq     = |status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        force_q <= '0;
    else if (force_we) force_q <= force_d;
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_OUT = 2,
  localparam int IDX_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_done,
  input  logic [NUM_CH-1:0] chan_quiet,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NUM_CH-1:0] reg_wdata,
  output logic [NUM_CH-1:0] reg_rdata,
  output logic [NUM_OUT-1:0] irq
);
  logic                           rst_sync_n;
  reg_kind_e                      kind;
  logic [IDX_W-1:0]               idx;
  logic [NUM_CH-1:0]              clr_vec;
  logic [NUM_CH-1:0]              pend_q;
  logic [NUM_OUT-1:0][NUM_CH-1:0] mask_q;
  logic [NUM_OUT-1:0][NUM_CH-1:0] force_q;
  logic [NUM_OUT-1:0][NUM_CH-1:0] status;

  assign kind = reg_kind_e'(reg_addr[1:0]);
  assign idx  = reg_addr[ADDR_W-1:2];

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    clr_vec = '0;
    if (reg_we && (kind == KIND_PENDING || kind == KIND_STATUS))
      clr_vec = reg_wdata;
  end

  irq_pending #(.NUM_CH(NUM_CH)) u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .done    (chan_done),
    .quiet   (chan_quiet),
    .clr_vec (clr_vec),
    .pend_q  (pend_q)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic sel_k;
    assign sel_k = reg_we && (32'(idx) == k);

    irq_out_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .mask_we  (sel_k && kind == KIND_MASK),
      .force_we (sel_k && kind == KIND_FORCE),
      .wdata    (reg_wdata),
      .pend     (pend_q),
      .mask_q   (mask_q[k]),
      .force_q  (force_q[k]),
      .status   (status[k]),
      .irq      (irq[k])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (kind == KIND_PENDING) begin
      reg_rdata = pend_q;
    end else begin
      for (int k = 0; k < NUM_OUT; k++) begin
        if (32'(idx) == k) begin
          case (kind)
            KIND_MASK:   reg_rdata = mask_q[k];
            KIND_FORCE:  reg_rdata = force_q[k];
            KIND_STATUS: reg_rdata = status[k];
            default:     reg_rdata = pend_q;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int NUM_CH  = 16,
  parameter int NUM_OUT = 2,
  parameter int ADDR_W  = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CH-1:0]              chan_done,
  input logic [NUM_CH-1:0]              chan_quiet,
  input logic                           reg_we,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [NUM_CH-1:0]              reg_wdata,
  input logic [NUM_CH-1:0]              pend_q,
  input logic [NUM_OUT-1:0][NUM_CH-1:0] mask_q,
  input logic [NUM_OUT-1:0][NUM_CH-1:0] force_q,
  input logic [NUM_OUT-1:0]             irq
);
  logic              seen_q;
  logic [NUM_CH-1:0] set_now;
  logic              is_clear;
  logic              is_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assign set_now  = chan_done & ~chan_quiet;
  assign is_clear = reg_we && (reg_addr[1:0] == 2'b00 || reg_addr[1:0] == 2'b11);
  assign is_force = reg_we && reg_addr[1:0] == 2'b10;

  // R2, R6: every enabled pulse is pending on the next edge
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((pend_q & $past(set_now)) == $past(set_now)));

  // R3: no pending bit rises without an enabled pulse
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((pend_q & ~$past(pend_q) & ~$past(set_now)) == '0));

  // R4, R5: cleared bits without a pulse are zero afterwards
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(is_clear)) |-> ((pend_q & $past(reg_wdata) & ~$past(set_now)) == '0));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_k
    // R8: force vectors move only on a force write
    p_force_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !$past(is_force)) |-> $stable(force_q[k]));

    // R10: irq line follows masked status
    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq[k] == (((pend_q | force_q[k]) & mask_q[k]) != '0));
  end
endmodule

bind dma_irq_agg dma_irq_agg_chk #(
  .NUM_CH (NUM_CH),
  .NUM_OUT(NUM_OUT),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .chan_done  (chan_done),
  .chan_quiet (chan_quiet),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .force_q    (force_q),
  .irq        (irq)
);

// File: tb/dma_irq_agg_tb_top.sv
`timescale 1ns/100ps
module dma_irq_agg_tb_top;
  localparam int NCH  = 16;
  localparam int NOUT = 2;
  localparam int AW   = 3;

  logic            clk;
  logic            rst_n;
  logic [NCH-1:0]  chan_done;
  logic [NCH-1:0]  chan_quiet;
  logic            reg_we;
  logic [AW-1:0]   reg_addr;
  logic [NCH-1:0]  reg_wdata;
  logic [NCH-1:0]  reg_rdata;
  logic [NOUT-1:0] irq;

  int n_chk;
  int n_bad;

  logic [NCH-1:0] m_pend;
  logic [NCH-1:0] m_mask  [NOUT];
  logic [NCH-1:0] m_force [NOUT];

  dma_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .chan_done(chan_done), .chan_quiet(chan_quiet),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [NCH-1:0] exp_status(int k);
    return (m_pend | m_force[k]) & m_mask[k];
  endfunction

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_all();
    for (int k = 0; k < NOUT; k++) begin
      reg_addr = AW'({k[0], 2'b00}); #0.4;
      check("R4 pending read", reg_rdata, m_pend);
      reg_addr = AW'({k[0], 2'b01}); #0.4;
      check("R7 mask read", reg_rdata, m_mask[k]);
      reg_addr = AW'({k[0], 2'b10}); #0.4;
      check("R8 force read", reg_rdata, m_force[k]);
      reg_addr = AW'({k[0], 2'b11}); #0.4;
      check("R9 status read", reg_rdata, exp_status(k));
      check("R10 irq line", NCH'(irq[k]), NCH'(exp_status(k) != '0));
    end
  endtask

  // one vector: drive, clock, update model, compare
  task automatic apply(logic [NCH-1:0] d, logic [NCH-1:0] q, logic we,
                       logic [AW-1:0] a, logic [NCH-1:0] w);
    logic [NCH-1:0] clr;
    int             k;
    @(negedge clk);
    chan_done = d; chan_quiet = q; reg_we = we; reg_addr = a; reg_wdata = w;
    @(posedge clk);
    k   = int'(a[AW-1:2]);
    clr = (we && (a[1:0] == 2'b00 || a[1:0] == 2'b11)) ? w : '0;
    m_pend = (m_pend & ~clr) | (d & ~q);
    if (we && a[1:0] == 2'b01) m_mask[k]  = w;
    if (we && a[1:0] == 2'b10) m_force[k] = w;
    @(negedge clk);
    chan_done = '0; reg_we = 1'b0;
    read_all();
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0; chan_done = '0; chan_quiet = '0; reg_we = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    m_pend = '0;
    for (int k = 0; k < NOUT; k++) begin m_mask[k] = '0; m_force[k] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    read_all(); // R1 reset state

    // R2: plain pulses, then R3 quiet pulses
    apply(16'h0011, 16'h0000, 1'b0, 3'b000, '0);
    apply(16'h0100, 16'h0100, 1'b0, 3'b000, '0);
    check("R3 quiet bit stays low", m_pend & 16'h0100, 16'h0000);
    // R7 mask both outputs, R11 separation
    apply('0, '0, 1'b1, 3'b001, 16'h00f0);
    apply('0, '0, 1'b1, 3'b101, 16'h000f);
    // R8 force output 1, then pulses and clears leave it
    apply('0, '0, 1'b1, 3'b110, 16'h0008);
    apply(16'h0008, '0, 1'b1, 3'b000, 16'h00ff);
    // R6 pulse plus clear on the same bit
    apply(16'h0020, '0, 1'b1, 3'b000, 16'h0020);
    // R5 clear through status address of output 1
    apply('0, '0, 1'b1, 3'b111, 16'hffff);
    check("R5 pending empty", m_pend, 16'h0000);

    for (int i = 0; i < 400; i++) begin
      logic [NCH-1:0] d, q, w;
      logic           we;
      logic [AW-1:0]  a;
      d  = NCH'($urandom) & NCH'($urandom);
      q  = NCH'($urandom) & NCH'($urandom);
      we = ($urandom % 3) != 0;
      a  = AW'($urandom);
      w  = NCH'($urandom);
      apply(d, q, we, a, w); // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule